// File: doc/BRIEF.md
# Dual-Buffer Frame Receiver with Destination Filter

This block takes received frames as a byte stream (one byte per cycle while `rxValid` is high, `rxLast` marking the final byte). It checks each frame's destination address and stores accepted frames in one of two 2 KiB receive buffers. Software reaches the buffers through a 32-bit register port. Each buffer ends in a control word. That word holds a full flag, which the hardware sets and software clears, and an interrupt enable bit.

A frame is kept if its first byte has the group bit (bit 7) set, or if its first six bytes equal the station address. A frame is discarded when the active buffer is already full as it begins, or when it is longer than the buffer's data area. After a frame is stored, the block marks the buffer full. It can raise a one-cycle interrupt pulse. When ping-pong mode is on, it moves to the other buffer for the next frame. `rxReady` tells the upstream stage whether the active buffer can take a frame.

Top module: `pingpong_rx`

## Requirements
- R1: After reset the active buffer is buffer 0, `rxReady` is high, and the control words at 0x17FC and 0x1FFC and the global enable word at 0x07F8 read zero.
- R2: A frame is accepted if bit 7 of its first byte is 1, or if its first six bytes equal `stationAddr` (bits 47:40 compared with the first byte, bits 7:0 with the sixth). Any other frame, including an individual-address frame shorter than six bytes, is discarded and leaves the control words unchanged.
- R3: An accepted frame is stored in the active buffer's data area: buffer 0 starts at 0x1000 and buffer 1 at 0x1800. Frame byte n goes to word n/4, bits 8*(n%4)+7 down to 8*(n%4). The unused bytes of the final word read zero.
- R4: When a frame is accepted, bit 0 (full) of the active buffer's control word (0x17FC for buffer 0, 0x1FFC for buffer 1) becomes 1.
- R5: `rxReady` is low exactly while the active buffer's full bit is 1. A frame whose first byte arrives then is dropped whole: the buffer's contents, both control words and the active buffer do not change.
- R6: The data area of each buffer is 2044 bytes. A frame of 2045 bytes or more is dropped, with no change to the full bit or the active buffer. A frame of exactly 2044 bytes is stored in full.
- R7: `irqPulse` is high for the single cycle after the clock edge that takes the last byte of an accepted frame. This happens only if bit 3 of buffer 0's control word and bit 31 of the global enable word (0x07F8) were both 1, whichever buffer took the frame.
- R8: With `pingPongEn` high, the active buffer alternates after each accepted frame. With it low, the frame after an accepted one goes to buffer 0.
- R9: A register write to a control word sets its bit 0 and bit 3 to the written values; its other bits read zero. Writing bit 0 as 0 frees the buffer. A write to 0x07F8 sets the global enable from bit 31. `regRdData` carries the addressed word from the clock edge that samples `regRdEn`.
- R10: A discarded or dropped frame leaves the active buffer selection and both full bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxLast | input | 1 | Marks the final byte of a frame |
| rxReady | output | 1 | Active buffer can take a frame |
| stationAddr | input | 48 | Station address, first byte in bits 47:40 |
| pingPongEn | input | 1 | Alternate between the two buffers |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 13 | Byte address of the register word |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| irqPulse | output | 1 | One-cycle receive interrupt |

## Verification
The clock edge that samples the last byte of an accepted frame does three things at once: it writes the final data word, sets the full bit (so `rxReady` drops if the active buffer is now full), and moves the active buffer. `irqPulse` is high only for the cycle after that edge. Read data arrives one edge after `regRdEn` is sampled. The bench drives inputs on the falling edge and updates its behavioural model just after the rising edge that takes each byte or register write. On every falling edge it compares `rxReady` and `irqPulse` with the model. It samples each register read at the falling edge that follows the read's rising edge.

// File: rtl/pingpong_rx_pkg.sv
package pingpong_rx_pkg;

  // Strobes from the frame control to the storage datapath.
  typedef struct packed {
    logic storeByte;  // place the current byte into the word being built
    logic lastByte;   // current byte closes the frame: flush the word
    logic commit;     // frame accepted: mark full, advance buffer
  } rxStrobes_t;

  localparam int unsigned CTRL_FULL_BIT = 0;
  localparam int unsigned CTRL_IE_BIT   = 3;
  localparam int unsigned GIE_BIT       = 31;
  localparam int unsigned NUM_BUFS      = 2;
  localparam int unsigned ADDR_BYTES    = 6;

endpackage

// File: rtl/pingpong_rx_ctrl.sv
module pingpong_rx_ctrl
  import pingpong_rx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxLast,
  input  logic [47:0]      stationAddr,
  input  logic             activeFull,
  output rxStrobes_t       stb,
  output logic [IDX_W-1:0] byteIdx,
  output logic             inFrame
);

  localparam int unsigned DATA_BYTES = BUF_BYTES - 4;
  localparam int unsigned CNT_W      = IDX_W + 1;

  logic [CNT_W-1:0] byteCnt;
  logic             dropFullQ, groupQ, matchQ, ovfQ;

  logic             first;
  logic [CNT_W-1:0] curIdx;
  logic             curDropFull, curGroup, curMatch, curOvf, tooLong, inAddr;
  logic [7:0]       addrByte;

  assign first       = !inFrame;
  assign curIdx      = first ? '0 : byteCnt;
  assign curDropFull = first ? activeFull : dropFullQ;
  assign curGroup    = first ? rxData[7] : groupQ;
  assign inAddr      = curIdx < CNT_W'(ADDR_BYTES);
  assign tooLong     = curIdx >= CNT_W'(DATA_BYTES);
  assign curOvf      = (first ? 1'b0 : ovfQ) || tooLong;

  always_comb begin
    case (curIdx[2:0])
      3'd0:    addrByte = stationAddr[47:40];
      3'd1:    addrByte = stationAddr[39:32];
      3'd2:    addrByte = stationAddr[31:24];
      3'd3:    addrByte = stationAddr[23:16];
      3'd4:    addrByte = stationAddr[15:8];
      3'd5:    addrByte = stationAddr[7:0];
      default: addrByte = 8'h00;
    endcase
  end

  assign curMatch = (first ? 1'b1 : matchQ) && (!inAddr || (rxData == addrByte));

  assign stb.storeByte = rxValid && !curDropFull && !curOvf;
  assign stb.lastByte  = rxValid && rxLast;
  assign stb.commit    = rxValid && rxLast && !curDropFull && !curOvf &&
                         (curGroup || (curMatch && curIdx >= CNT_W'(ADDR_BYTES - 1)));
  assign byteIdx       = curIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      byteCnt   <= '0;
      dropFullQ <= 1'b0;
      groupQ    <= 1'b0;
      matchQ    <= 1'b0;
      ovfQ      <= 1'b0;
    end else if (rxValid) begin
      inFrame   <= !rxLast;
      dropFullQ <= curDropFull;
      groupQ    <= curGroup;
      matchQ    <= curMatch;
      ovfQ      <= curOvf;
      byteCnt   <= tooLong ? curIdx : curIdx + 1'b1;
    end
  end

endmodule

// File: rtl/pingpong_rx_dp.sv
module pingpong_rx_dp
  import pingpong_rx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned ADDR_W    = $clog2(BUF_BYTES) + 2,
  parameter int unsigned GIE_ADDR  = 'h07F8,
  parameter int unsigned IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxData,
  input  rxStrobes_t        stb,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic              pingPongEn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              activeFull,
  output logic              activeIdx,
  output logic              gieOn,
  output logic              irqPulse
);

  localparam int unsigned BUF_WORDS = BUF_BYTES / 4;
  localparam int unsigned WORD_W    = $clog2(BUF_WORDS);

  logic [31:0] mem [NUM_BUFS * BUF_WORDS];
  logic [31:0] wordBuf, assembled, rdMux;
  logic [1:0]  lane;
  logic [WORD_W-1:0] wordIdx, wordSel;
  logic [NUM_BUFS-1:0] fullQ, ieQ;
  logic        inRx, isCtrl, isGie, bufSel;
  logic        unusedWrBits;

  assign unusedWrBits = ^{regWrData[30:4], regWrData[2:1]};

  // Byte packing, least significant byte first
  assign lane    = byteIdx[1:0];
  assign wordIdx = byteIdx[IDX_W-1:2];

  always_comb begin
    assembled = (lane == 2'd0) ? '0 : wordBuf;
    assembled[{lane, 3'b000} +: 8] = rxData;
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) begin
      wordBuf <= assembled;
      if (lane == 2'd3 || stb.lastByte) mem[{activeIdx, wordIdx}] <= assembled;
    end
  end

  // Register decode
  assign inRx    = regAddr[ADDR_W-1];
  assign bufSel  = regAddr[IDX_W];
  assign wordSel = regAddr[IDX_W-1:2];
  assign isCtrl  = inRx && (wordSel == WORD_W'(BUF_WORDS - 1));
  assign isGie   = regAddr == ADDR_W'(GIE_ADDR);

  // Per-buffer control words
  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fullQ[b] <= 1'b0;
        ieQ[b]   <= 1'b0;
      end else begin
        if (regWrEn && isCtrl && (bufSel == 1'(b))) begin
          fullQ[b] <= regWrData[CTRL_FULL_BIT];
          ieQ[b]   <= regWrData[CTRL_IE_BIT];
        end
        if (stb.commit && (activeIdx == 1'(b))) fullQ[b] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieOn     <= 1'b0;
      activeIdx <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (regWrEn && isGie) gieOn <= regWrData[GIE_BIT];
      if (stb.commit) activeIdx <= pingPongEn ? !activeIdx : 1'b0;
      irqPulse <= stb.commit && ieQ[0] && gieOn;
    end
  end

  assign activeFull = fullQ[activeIdx];

  always_comb begin
    if (isGie)       rdMux = {gieOn, 31'b0};
    else if (isCtrl) rdMux = {28'b0, ieQ[bufSel], 2'b00, fullQ[bufSel]};
    else if (inRx)   rdMux = mem[{bufSel, wordSel}];
    else             rdMux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

endmodule

// File: rtl/pingpong_rx.sv
module pingpong_rx
  import pingpong_rx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned ADDR_W    = $clog2(BUF_BYTES) + 2,
  parameter int unsigned GIE_ADDR  = 'h07F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  output logic              rxReady,
  input  logic [47:0]       stationAddr,
  input  logic              pingPongEn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqPulse
);

  localparam int unsigned IDX_W = $clog2(BUF_BYTES);

  rxStrobes_t       stb;
  logic [IDX_W-1:0] byteIdx;
  logic             activeFull, activeIdx, gieOn, inFrame, commitStb;

  assign commitStb = stb.commit;
  assign rxReady   = !activeFull;

  pingpong_rx_ctrl #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .stationAddr(stationAddr), .activeFull(activeFull), .stb(stb),
    .byteIdx(byteIdx), .inFrame(inFrame)
  );

  pingpong_rx_dp #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .GIE_ADDR(GIE_ADDR),
                   .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .stb(stb), .byteIdx(byteIdx),
    .pingPongEn(pingPongEn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .activeFull(activeFull), .activeIdx(activeIdx), .gieOn(gieOn),
    .irqPulse(irqPulse)
  );

endmodule

// File: rtl/pingpong_rx_checker.sv
module pingpong_rx_checker (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic rxReady,
  input logic pingPongEn,
  input logic irqPulse,
  input logic commitStb,
  input logic inFrame,
  input logic gieOn,
  input logic activeIdx
);

  AST_IRQ_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(commitStb)); // R7
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(gieOn)); // R7
  AST_PINGPONG_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && pingPongEn) |=> (activeIdx != $past(activeIdx))); // R8
  AST_SINGLE_BUF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && !pingPongEn) |=> (activeIdx == 1'b0)); // R8
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !commitStb |=> $stable(activeIdx)); // R10
  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !inFrame && !rxReady) |-> !commitStb); // R5

endmodule

bind pingpong_rx pingpong_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxReady(rxReady),
  .pingPongEn(pingPongEn), .irqPulse(irqPulse), .commitStb(commitStb),
  .inFrame(inFrame), .gieOn(gieOn), .activeIdx(activeIdx)
);

// File: tb/test_pingpong_rx.sv
module test_pingpong_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_BYTES = 2044;
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxLast = 1'b0, pingPongEn = 1'b1;
  logic [7:0]  rxData = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [12:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        rxReady, irqPulse;
  logic [31:0] regRdData;

  pingpong_rx i_pingpong_rx (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxReady(rxReady), .stationAddr(STA), .pingPongEn(pingPongEn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  // Behavioural reference model
  logic [7:0] mBuf [2][2048];
  bit mStatus [2];
  bit mIe [2];
  bit mGie, mIdx, irqExp, done;
  int checks = 0, errors = 0;
  logic [7:0] frm [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [12:0] a);
    int b, w;
    if (a == 13'h07F8) return {mGie, 31'b0};
    if (!a[12]) return '0;
    b = int'(a[11]);
    w = int'(a[10:2]);
    if (w == 511) return {28'b0, mIe[b], 2'b00, mStatus[b]};
    return {mBuf[b][4*w+3], mBuf[b][4*w+2], mBuf[b][4*w+1], mBuf[b][4*w]};
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rxReady == !mStatus[mIdx], "R5 rxReady vs full flag", 32'(rxReady),
            32'(!mStatus[mIdx]));
      check(irqPulse == irqExp, "R7 irqPulse", 32'(irqPulse), 32'(irqExp));
      irqExp = 1'b0;
    end
  end

  task automatic sendFrame(input logic [7:0] fr[$]);
    bit drop, grp, match, accept;
    int n;
    n = fr.size();
    drop = mStatus[mIdx];
    grp = fr[0][7];
    match = n >= 6;
    for (int i = 0; i < 6 && i < n; i++) if (fr[i] != STA[47-8*i -: 8]) match = 0;
    accept = !drop && n <= DATA_BYTES && (grp || match);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxData = fr[i];
      rxLast = (i == n - 1);
    end
    @(posedge clk);
    if (accept) begin
      for (int i = 0; i < n; i++) mBuf[mIdx][i] = fr[i];
      for (int i = n; i % 4 != 0; i++) mBuf[mIdx][i] = 8'h00;
      mStatus[mIdx] = 1'b1;
      irqExp = mIe[0] && mGie;
      mIdx = pingPongEn ? !mIdx : 1'b0;
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxLast = 1'b0;
  endtask

  task automatic writeReg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = d;
    @(posedge clk);
    if (a == 13'h17FC || a == 13'h1FFC) begin
      mStatus[a[11]] = d[0];
      mIe[a[11]] = d[3];
    end
    if (a == 13'h07F8) mGie = d[31];
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readExpect(input logic [12:0] a, input logic [31:0] exp,
                            input string tag);
    @(negedge clk);
    regRdEn = 1'b1;
    regAddr = a;
    @(posedge clk);
    @(negedge clk);
    regRdEn = 1'b0;
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic readModel(input logic [12:0] a, input string tag);
    readExpect(a, modelRead(a), tag);
  endtask

  task automatic groupFrame(input int n);
    frm.delete();
    frm.push_back(8'h81);
    for (int i = 1; i < n; i++) frm.push_back(8'(i));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired, run incomplete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(rxReady == 1'b1, "R1 rxReady after reset", 32'(rxReady), 32'd1);
    readExpect(13'h17FC, 32'h0, "R1 ctrl0 after reset");
    readExpect(13'h1FFC, 32'h0, "R1 ctrl1 after reset");
    readExpect(13'h07F8, 32'h0, "R1 global enable after reset");

    writeReg(13'h07F8, 32'h8000_0000);
    writeReg(13'h17FC, 32'h0000_0008);
    readExpect(13'h07F8, 32'h8000_0000, "R9 global enable write");

    // Matching individual address, 10 bytes -> buffer 0 (R1 index)
    frm = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hA0, 8'hA1, 8'hA2, 8'hA3};
    sendFrame(frm);
    readExpect(13'h1000, 32'h3322_1102, "R3 word0 lsb first");
    readExpect(13'h1004, 32'hA1A0_5544, "R3 word1");
    readExpect(13'h1008, 32'h0000_A3A2, "R3 partial word zero pad");
    readExpect(13'h17FC, 32'h0000_0009, "R4 full bit buffer0");

    // Mismatch in last address byte -> discarded
    frm = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56, 8'h01, 8'h02};
    sendFrame(frm);
    readExpect(13'h1FFC, 32'h0, "R2 mismatch discarded");
    check(rxReady == 1'b1, "R10 ready after discard", 32'(rxReady), 32'd1);
    // Short individual frame
    frm = '{8'h02, 8'h11, 8'h22, 8'h33};
    sendFrame(frm);
    readExpect(13'h1FFC, 32'h0, "R2 short frame discarded");

    // Group frame -> buffer 1, irq from buffer 0 enable
    groupFrame(7);
    sendFrame(frm);
    readExpect(13'h1FFC, 32'h0000_0001, "R4 full bit buffer1");
    readExpect(13'h1800, 32'h0302_0181, "R3 buffer1 word0");
    readExpect(13'h1804, 32'h0006_0504, "R3 buffer1 padded word");
    check(rxReady == 1'b0, "R5 ready low on full active", 32'(rxReady), 32'd0);

    // Frame while full -> dropped
    groupFrame(5);
    sendFrame(frm);
    readExpect(13'h1000, 32'h3322_1102, "R5 contents kept");
    readExpect(13'h17FC, 32'h0000_0009, "R5 ctrl0 unchanged");
    readExpect(13'h1FFC, 32'h0000_0001, "R10 ctrl1 unchanged");

    // Free both buffers
    writeReg(13'h17FC, 32'h0000_0008);
    check(rxReady == 1'b1, "R9 free restores ready", 32'(rxReady), 32'd1);
    writeReg(13'h1FFC, 32'h0);

    // Oversize and exact-size frames
    groupFrame(DATA_BYTES + 1);
    sendFrame(frm);
    readExpect(13'h17FC, 32'h0000_0008, "R6 oversize dropped");
    groupFrame(DATA_BYTES);
    sendFrame(frm);
    readExpect(13'h17FC, 32'h0000_0009, "R6 exact size stored");
    readExpect(13'h17F8, 32'hFBFA_F9F8, "R6 last data word");

    // Global enable off: no irq (monitor), still stored in buffer 1
    writeReg(13'h07F8, 32'h0);
    groupFrame(9);
    sendFrame(frm);
    readExpect(13'h1FFC, 32'h0000_0001, "R7 stored with gie off");

    // Only buffer 0 enable counts
    writeReg(13'h07F8, 32'h8000_0000);
    writeReg(13'h17FC, 32'h0);
    writeReg(13'h1FFC, 32'h0000_0008);
    groupFrame(6);
    sendFrame(frm);
    groupFrame(11);
    sendFrame(frm);
    readExpect(13'h1FFC, 32'h0000_0009, "R7 buffer1 stored without irq");
    readModel(13'h1808, "R3 buffer1 word2");

    // Ping-pong off
    writeReg(13'h17FC, 32'h0000_0008);
    writeReg(13'h1FFC, 32'h0);
    groupFrame(4);
    sendFrame(frm);
    pingPongEn = 1'b0;
    groupFrame(8);
    sendFrame(frm);
    readExpect(13'h1FFC, 32'h0000_0001, "R8 frame in buffer1");
    groupFrame(3);
    sendFrame(frm);
    writeReg(13'h17FC, 32'h0000_0008);
    frm = '{8'hC5, 8'h10, 8'h20};
    sendFrame(frm);
    readExpect(13'h1000, 32'h0020_10C5, "R8 single-buffer mode uses buffer0");
    check(rxReady == 1'b0, "R8 stays on full buffer0", 32'(rxReady), 32'd0);
    readModel(13'h17FC, "R8 ctrl0");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule